// File: doc/BRIEF.md
# Transmit Precomputed FCS Checker

This block sits beside a byte-wide transmit path and audits frames that carry their own frame check sequence. When a frame is queued with the request to send it without a generated FCS, the block runs a reflected CRC-32 over every byte of the frame, including the four trailing check bytes. It then compares the final register against the fixed CRC-32 residue. On a mismatch it raises a sticky status bit that reports that a frame with a bad CRC went out on the line.

The block only observes. It never stalls, alters or drops a byte, so the frame is transmitted in full whatever the check finds. Frames that end in an abort are fragments, and they never raise the status bit. The frame-class indication does not change the outcome, so frames of the reserved implementor class are audited exactly like ordinary frames. Software or a neighbouring block clears the bit through a clear input.

Top module: `txfcs_audit`

## Requirements
- R1: The no-append request is sampled in the cycle that carries the accepted start byte and governs the whole frame. A frame whose sampled request is 0 never sets the status bit, and later changes of the request within the frame have no effect.
- R2: For an audited frame, the register is preset to 0xFFFFFFFF and updated LSB-first with polynomial 0x04C11DB7 (reflected form 0xEDB88320) over all bytes, the four FCS bytes included. The status bit is set in the cycle after the accepted last byte if the final register differs from the residue 0xDEBB20E3 (0xC704DD7B in non-reflected bit order). It is left unchanged otherwise.
- R3: The frame-class input (1 = reserved implementor class) has no effect on the check or on the status bit.
- R4: An abort asserted during a frame, including in the cycle of its last byte, ends that frame without setting the status bit. Bytes that follow, up to the next accepted start, are ignored, including a byte with the last strobe set.
- R5: A cycle with valid low is ignored entirely. Its data, start, last and abort values affect neither the CRC nor the frame state.
- R6: An accepted start byte restarts the CRC from the preset value, even in the middle of a frame.
- R7: Once set, the status bit holds until the clear input is high at a clock edge. It then reads 0 in the following cycle.
- R8: If a set event and the clear input occur at the same edge, the status bit reads 1 afterwards.
- R9: While reset is active, and after it is released, the status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A byte is present on the stream this cycle |
| s_data | input | 8 | Stream byte |
| s_start | input | 1 | First byte of a frame |
| s_last | input | 1 | Final byte of a frame |
| s_abort | input | 1 | Frame is cut off as a fragment |
| req_no_fcs | input | 1 | Frame carries its own FCS (sampled with the start byte) |
| req_impl_class | input | 1 | Frame is of the reserved implementor class |
| flag_clr | input | 1 | Clears the status bit |
| bad_fcs_sent | output | 1 | Sticky bad-CRC-sent status |

## Verification
The status bit answers a frame exactly one cycle after the edge that takes the last byte. It answers a clear one cycle after the edge that samples the clear. The bench drives each stimulus at a falling edge and reads the status at the falling edge that follows the next rising edge. That read falls on the cycle in which the registered result is first due. Expected outcomes come from a separate MSB-first CRC over bit-reversed bytes, compared against the non-reflected residue. This exercises the design's reflected arithmetic from an independent direction.

// File: rtl/txfcs_pkg.sv
package txfcs_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB20E3;

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/txfcs_frame_ctl.sv
module txfcs_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_start,
  input  logic s_last,
  input  logic s_abort,
  input  logic req_no_fcs,
  output logic byte_take,
  output logic byte_first,
  output logic frame_end,
  output logic audit_mode
);
  logic in_frame_q;
  logic mode_q;

  assign byte_take  = s_valid && !s_abort && (s_start || in_frame_q);
  assign byte_first = byte_take && s_start;
  assign frame_end  = byte_take && s_last;
  assign audit_mode = byte_first ? req_no_fcs : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      if (s_valid && s_abort)  in_frame_q <= 1'b0;
      else if (frame_end)      in_frame_q <= 1'b0;
      else if (byte_first)     in_frame_q <= 1'b1;
      if (byte_first) mode_q <= req_no_fcs;
    end
  end

  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_abort) |=> !in_frame_q) else $error("abort left frame open"); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_first) |=> (mode_q == $past(mode_q))) else $error("mode changed mid-frame"); // R1
endmodule

// File: rtl/txfcs_crc_acc.sv
module txfcs_crc_acc
  import txfcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              byte_first,
  input  logic [BYTE_W-1:0] data,
  output logic              bad_residue
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;

  assign crc_base    = byte_first ? CRC_PRESET : crc_q;
  assign crc_next    = crc_step(crc_base, data);
  assign bad_residue = (crc_next != CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC_PRESET;
    else if (byte_en) crc_q <= crc_next;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_en) |=> $stable(crc_q)) else $error("crc moved on idle cycle"); // R5
  AST_CRC_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && byte_first) |=> (crc_q == crc_step(CRC_PRESET, $past(data))))
    else $error("crc not restarted"); // R6
endmodule

// File: rtl/txfcs_flag.sv
module txfcs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag) else $error("set lost"); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag) else $error("flag dropped"); // R7
  AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag) else $error("clear ignored"); // R7
endmodule

// File: rtl/txfcs_audit.sv
module txfcs_audit
  import txfcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_start,
  input  logic              s_last,
  input  logic              s_abort,
  input  logic              req_no_fcs,
  input  logic              req_impl_class,
  input  logic              flag_clr,
  output logic              bad_fcs_sent
);
  logic byte_take, byte_first, frame_end, audit_mode;
  logic bad_residue, set_evt;
  logic unused_class;

  // Implementor-class frames are audited like any other frame.
  assign unused_class = req_impl_class;

  txfcs_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_start(s_start),
    .s_last(s_last), .s_abort(s_abort), .req_no_fcs(req_no_fcs),
    .byte_take(byte_take), .byte_first(byte_first),
    .frame_end(frame_end), .audit_mode(audit_mode));

  txfcs_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_take), .byte_first(byte_first),
    .data(s_data), .bad_residue(bad_residue));

  assign set_evt = frame_end && audit_mode && bad_residue;

  txfcs_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr(flag_clr),
    .flag(bad_fcs_sent));

  AST_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_fcs_sent) |-> $past(s_valid && s_last && !s_abort))
    else $error("flag rose without a frame end"); // R2
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_abort) |=> (bad_fcs_sent == ($past(bad_fcs_sent) && !$past(flag_clr))))
    else $error("aborted frame touched flag"); // R4
  AST_APPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_first && !req_no_fcs && s_last) |=> (bad_fcs_sent == ($past(bad_fcs_sent) && !$past(flag_clr))))
    else $error("append-mode frame touched flag"); // R1
endmodule

// File: tb/txfcs_audit_bench.sv
module txfcs_audit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_start = 1'b0, s_last = 1'b0, s_abort = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic req_no_fcs = 1'b0, req_impl_class = 1'b0, flag_clr = 1'b0;
  logic bad_fcs_sent;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] fb [0:31];
  int fb_len;

  always #4 clk = ~clk;

  txfcs_audit u_txfcs_audit (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_start(s_start), .s_last(s_last), .s_abort(s_abort),
    .req_no_fcs(req_no_fcs), .req_impl_class(req_impl_class),
    .flag_clr(flag_clr), .bad_fcs_sent(bad_fcs_sent));

  function automatic [7:0] rev8(input [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction
  function automatic [31:0] rev32(input [31:0] w);
    for (int i = 0; i < 32; i++) rev32[i] = w[31-i];
  endfunction
  // Non-reflected CRC over bit-reversed bytes.
  function automatic [31:0] msb_step(input [31:0] r_in, input [7:0] b);
    logic [31:0] r; logic [7:0] rb; logic fbk;
    r = r_in; rb = rev8(b);
    for (int i = 7; i >= 0; i--) begin
      fbk = r[31] ^ rb[i];
      r = {r[30:0], 1'b0};
      if (fbk) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: bad_fcs_sent=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0; s_last = 1'b0; s_abort = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0; s_last = 1'b0; s_abort = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // Build payload of len bytes plus correct FCS, optionally corrupt one byte.
  // Returns expected "bad" from residue of the whole frame.
  function automatic logic build(input int len, input int seed, input logic corrupt);
    logic [31:0] r, fcs;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      fb[i] = 8'((i * 37 + seed * 11) ^ (seed * 5 + 3));
      r = msb_step(r, fb[i]);
    end
    fcs = ~rev32(r);
    for (int k = 0; k < 4; k++) fb[len+k] = fcs[8*k +: 8];
    fb_len = len + 4;
    if (corrupt) fb[(len * 3) % fb_len] ^= 8'h10;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < fb_len; i++) r = msb_step(r, fb[i]);
    return r != 32'hC704DD7B;
  endfunction

  // Send fb[0..fb_len-1]; abort_at >= 0 puts abort on that byte.
  task automatic send(input logic nofcs, input logic cls, input logic gap,
                      input int abort_at, input logic clr_last);
    for (int i = 0; i < fb_len; i++) begin
      if (gap && (i % 2 == 1)) begin
        @(negedge clk);
        s_valid = 1'b0; s_data = 8'hA5; s_start = 1'b1; s_last = 1'b1; s_abort = 1'b1;
        flag_clr = 1'b0;
      end
      @(negedge clk);
      s_valid = 1'b1; s_data = fb[i]; s_start = (i == 0); s_last = (i == fb_len - 1);
      s_abort = (i == abort_at);
      req_no_fcs = (i == 0) ? nofcs : ~nofcs;
      req_impl_class = (i == 0) ? cls : ~cls;
      flag_clr = clr_last && (i == fb_len - 1);
    end
    idle_cycle();
  endtask

  initial begin
    logic bad;
    repeat (3) @(negedge clk);
    check("R9 in reset", bad_fcs_sent, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", bad_fcs_sent, 1'b0);

    // Sweep: lengths, request, class, corruption, valid gaps. R1 R2 R3 R5
    for (int len = 1; len <= 12; len++)
      for (int m = 0; m < 16; m++) begin
        bad = build(len, len * 16 + m, m[2]);
        send(m[0], m[1], m[3], -1, 1'b0);
        check(m[0] ? (m[1] ? "R3 impl-class audit" : "R2 audit")
                   : "R1 append-mode ignored",
              bad_fcs_sent, m[0] & bad);
        do_clear();
      end

    // R7: sticky then clear
    bad = build(6, 3, 1'b1);
    send(1'b1, 1'b0, 1'b0, -1, 1'b0);
    repeat (5) idle_cycle();
    check("R7 sticky", bad_fcs_sent, 1'b1);
    do_clear();
    check("R7 cleared", bad_fcs_sent, 1'b0);

    // R8: set and clear together while flag already 1, and while 0
    bad = build(5, 9, 1'b1);
    send(1'b1, 1'b0, 1'b0, -1, 1'b0);
    send(1'b1, 1'b0, 1'b0, -1, 1'b1);
    check("R8 set beats clear (was 1)", bad_fcs_sent, 1'b1);
    do_clear();
    send(1'b1, 1'b1, 1'b0, -1, 1'b1);
    check("R8 set beats clear (was 0)", bad_fcs_sent, 1'b1);
    do_clear();

    // R4: abort mid-frame on bad frame; rest of bytes ignored
    bad = build(8, 21, 1'b1);
    send(1'b1, 1'b0, 1'b0, 4, 1'b0);
    check("R4 abort mid-frame", bad_fcs_sent, 1'b0);
    send(1'b1, 1'b0, 1'b0, fb_len - 1, 1'b0);
    check("R4 abort on last byte", bad_fcs_sent, 1'b0);
    // Orphan bytes after abort: last strobe without start
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h00; s_start = 1'b0; s_last = 1'b1; s_abort = 1'b0;
    idle_cycle();
    check("R4 orphan last ignored", bad_fcs_sent, 1'b0);

    // R6: restart mid-frame, then a good frame from the new start
    bad = build(7, 30, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 8'hC3 + 8'(i); s_start = (i == 0); s_last = 1'b0;
      s_abort = 1'b0; req_no_fcs = 1'b1;
    end
    send(1'b1, 1'b0, 1'b0, -1, 1'b0);
    check("R6 restart gives clean check", bad_fcs_sent, bad);
    do_clear();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule